// File: doc/BRIEF.md
# Receive-Side Link Lock Monitor

This block sits in the receive half of a serial video link and decides whether the receiver should be treated as locked to the transmitter. While the link carries video, it counts the decode-error pulses seen in consecutive windows of fixed length. If a window collects more errors than an allowed limit, lock is dropped at once.

The link alternates between a video phase and a control-channel phase. At each return from the control channel to video, the block asks the transmitter for a lock frame, provided the video phase before it stayed clean. It then waits for the outcome of the handshake. Lock is regained only when that handshake completes successfully.

Throughout the control-channel phase the lock indication is held at its last value. The recovered video word is frozen at the last value captured in the video phase, and a registered copy of the phase is driven out as the control-channel-active flag.

Top module: `link_lock_monitor`

## Requirements
- R1: In the video phase (`cc_phase_i` = 0), errors are counted in windows of WIN_LEN clock cycles. The count restarts at zero at the start of each window and on the first video cycle after a control-channel phase. `dec_err_i` and the window position are ignored while `cc_phase_i` = 1, so a window never spans a control-channel phase.
- R2: The clock edge that samples the (ERR_LIMIT+1)-th error of one window drives `lock_o` low from the next cycle. It abandons any handshake still pending and suppresses the lock-frame request at the next handshake point. Exactly ERR_LIMIT errors in a window leave `lock_o` unchanged.
- R3: The handshake point is the first edge that samples `cc_phase_i` = 0 after an edge that sampled 1 (reset counts as 1). If no over-limit event occurred since the previous handshake point, `frame_req_o` is high for exactly the one cycle after that edge and a handshake becomes pending. Otherwise `frame_req_o` stays low.
- R4: While a handshake is pending, `hs_ok_i` = 1 sets `lock_o` high in the next cycle and `hs_fail_i` = 1 sets it low. Either one ends the pending state, and `hs_fail_i` wins when both are high.
- R5: `hs_ok_i` and `hs_fail_i` have no effect when no handshake is pending, including on the handshake-point edge itself.
- R6: `lock_o` does not change on an edge that samples `cc_phase_i` = 1 with `cc_active_o` already 1. Entering the control-channel phase with a handshake still pending counts as a failed handshake: `lock_o` goes low in the cycle after the entry edge.
- R7: `vid_data_o` equals `vid_data_i` from the previous edge when that edge sampled `cc_phase_i` = 0. It holds the last such value through the control-channel phase.
- R8: `cc_active_o` is `cc_phase_i` delayed by one clock (1 = control channel, 0 = video).
- R9: Synchronous reset gives `lock_o` = 0, `frame_req_o` = 0, `cc_active_o` = 1, `vid_data_o` = 0 and empty error windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cc_phase_i | input | 1 | Link phase: 1 control channel, 0 video |
| dec_err_i | input | 1 | One-cycle pulse per decode error |
| hs_ok_i | input | 1 | Handshake completed successfully |
| hs_fail_i | input | 1 | Handshake failed |
| vid_data_i | input | DATA_W | Recovered video word |
| lock_o | output | 1 | Receiver locked to transmitter |
| cc_active_o | output | 1 | Control-channel phase active |
| frame_req_o | output | 1 | One-cycle request to send a lock frame |
| vid_data_o | output | DATA_W | Video word, frozen during control channel |

## Verification
The bench builds the block with WIN_LEN = 16, ERR_LIMIT = 3 and DATA_W = 8. With those values, window wrap-around occurs every sixteen video cycles and the limit is crossed with only four errors. Error bursts that straddle a window boundary, error rates just under the limit, and many full request/handshake rounds all fit in a few thousand cycles. The default window of 4096 would leave those boundaries rare.

// File: rtl/lock_mon_pkg.sv
package lock_mon_pkg;

  typedef enum logic {
    HS_IDLE    = 1'b0,
    HS_PENDING = 1'b1
  } hs_state_e;

  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/lock_err_window.sv
module lock_err_window #(
  parameter int unsigned WIN_LEN   = 4096,
  parameter int unsigned ERR_LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic video_i,
  input  logic start_i,
  input  logic err_i,
  output logic over_o
);
  import lock_mon_pkg::*;

  localparam int unsigned CW = cnt_width(WIN_LEN);
  localparam int unsigned EW = cnt_width(ERR_LIMIT + 2);
  localparam logic [CW-1:0] LAST_IDX = CW'(WIN_LEN - 1);
  localparam logic [EW-1:0] LIM      = EW'(ERR_LIMIT);
  localparam logic [EW-1:0] SAT      = EW'(ERR_LIMIT + 1);

  logic [CW-1:0] cyc_q, cyc_idx;
  logic [EW-1:0] err_q, err_base, err_next;
  logic          win_last;

  // A new video phase forces the window back to position zero.
  always_comb begin
    cyc_idx  = start_i ? '0 : cyc_q;
    err_base = start_i ? '0 : err_q;
    win_last = (cyc_idx == LAST_IDX);
    err_next = (err_i && (err_base != SAT)) ? err_base + EW'(1) : err_base;
    over_o   = video_i && err_i && (err_base == LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
      err_q <= '0;
    end else if (video_i) begin
      if (win_last) begin
        cyc_q <= '0;
        err_q <= '0;
      end else begin
        cyc_q <= cyc_idx + CW'(1);
        err_q <= err_next;
      end
    end
  end

  AST_CC_FREEZES_WINDOW: assert property (@(posedge clk) disable iff (rst)
    !video_i |=> ($stable(cyc_q) && $stable(err_q)));  // R1

endmodule

// File: rtl/lock_hs_ctrl.sv
module lock_hs_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic vid_start_i,
  input  logic cc_enter_i,
  input  logic over_i,
  input  logic hs_ok_i,
  input  logic hs_fail_i,
  output logic lock_o,
  output logic req_o
);
  import lock_mon_pkg::*;

  hs_state_e st_q, st_d;
  logic      bad_q, bad_d;
  logic      lock_q, lock_d;
  logic      req_q, req_d;

  always_comb begin
    st_d   = st_q;
    bad_d  = bad_q;
    lock_d = lock_q;
    req_d  = 1'b0;
    if (vid_start_i) begin
      req_d = !bad_q;
      st_d  = bad_q ? HS_IDLE : HS_PENDING;
      bad_d = 1'b0;
    end else if (cc_enter_i) begin
      if (st_q == HS_PENDING) begin
        st_d   = HS_IDLE;
        lock_d = 1'b0;
      end
    end else if (st_q == HS_PENDING) begin
      if (hs_fail_i) begin
        st_d   = HS_IDLE;
        lock_d = 1'b0;
      end else if (hs_ok_i) begin
        st_d   = HS_IDLE;
        lock_d = 1'b1;
      end
    end
    // An over-limit window overrides everything above.
    if (over_i) begin
      lock_d = 1'b0;
      bad_d  = 1'b1;
      st_d   = HS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= HS_IDLE;
      bad_q  <= 1'b0;
      lock_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bad_q  <= bad_d;
      lock_q <= lock_d;
      req_q  <= req_d;
    end
  end

  assign lock_o = lock_q;
  assign req_o  = req_q;

  AST_OVER_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    over_i |=> !lock_q);  // R2

  AST_RISE_NEEDS_OK: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> ($past(hs_ok_i) && !$past(hs_fail_i)));  // R4

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);  // R3

endmodule

// File: rtl/lock_data_hold.sv
module lock_data_hold #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              cc_q_o
);

  logic [DATA_W-1:0] data_q;
  logic              cc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      cc_q   <= 1'b1;
    end else begin
      cc_q <= cc_i;
      if (!cc_i) data_q <= data_i;
    end
  end

  assign data_o = data_q;
  assign cc_q_o = cc_q;

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst)
    cc_i |=> $stable(data_q));  // R7

endmodule

// File: rtl/link_lock_monitor.sv
module link_lock_monitor #(
  parameter int unsigned WIN_LEN   = 4096,
  parameter int unsigned ERR_LIMIT = 16,
  parameter int unsigned DATA_W    = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cc_phase_i,
  input  logic              dec_err_i,
  input  logic              hs_ok_i,
  input  logic              hs_fail_i,
  input  logic [DATA_W-1:0] vid_data_i,
  output logic              lock_o,
  output logic              cc_active_o,
  output logic              frame_req_o,
  output logic [DATA_W-1:0] vid_data_o
);

  logic cc_q;
  logic vid_start;
  logic cc_enter;
  logic over;

  assign vid_start = cc_q && !cc_phase_i;
  assign cc_enter  = !cc_q && cc_phase_i;

  lock_data_hold #(.DATA_W(DATA_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .cc_i   (cc_phase_i),
    .data_i (vid_data_i),
    .data_o (vid_data_o),
    .cc_q_o (cc_q)
  );

  lock_err_window #(.WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT)) u_win (
    .clk     (clk),
    .rst     (rst),
    .video_i (!cc_phase_i),
    .start_i (vid_start),
    .err_i   (dec_err_i),
    .over_o  (over)
  );

  lock_hs_ctrl u_hs (
    .clk         (clk),
    .rst         (rst),
    .vid_start_i (vid_start),
    .cc_enter_i  (cc_enter),
    .over_i      (over),
    .hs_ok_i     (hs_ok_i),
    .hs_fail_i   (hs_fail_i),
    .lock_o      (lock_o),
    .req_o       (frame_req_o)
  );

  assign cc_active_o = cc_q;

  AST_LOCK_HELD_IN_CC: assert property (@(posedge clk) disable iff (rst)
    (cc_phase_i && cc_active_o) |=> $stable(lock_o));  // R6

  AST_REQ_AT_VIDEO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    frame_req_o |-> (!cc_active_o && $past(cc_active_o)));  // R3

  AST_CC_FOLLOWS_PHASE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cc_active_o == $past(cc_phase_i)));  // R8

endmodule

// File: tb/test_link_lock_monitor.sv
module test_link_lock_monitor;

  localparam int WIN    = 16;
  localparam int LIM    = 3;
  localparam int DW     = 8;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cc  = 1'b1;
  logic          err = 1'b0;
  logic          ok  = 1'b0;
  logic          fl  = 1'b0;
  logic [DW-1:0] din = '0;
  logic          lock_o, cc_active_o, frame_req_o;
  logic [DW-1:0] vid_data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_lock_monitor #(.WIN_LEN(WIN), .ERR_LIMIT(LIM), .DATA_W(DW)) i_link_lock_monitor (
    .clk(clk), .rst(rst), .cc_phase_i(cc), .dec_err_i(err),
    .hs_ok_i(ok), .hs_fail_i(fl), .vid_data_i(din),
    .lock_o(lock_o), .cc_active_o(cc_active_o),
    .frame_req_o(frame_req_o), .vid_data_o(vid_data_o)
  );

  // Behavioural reference model
  int          m_win, m_err;
  bit          m_lock, m_pend, m_bad, m_ccq, m_req;
  bit          m_vs, m_ent, m_ov;
  logic [DW-1:0] m_data;

  always @(posedge clk) begin
    if (rst) begin
      m_win = 0; m_err = 0; m_lock = 0; m_pend = 0; m_bad = 0;
      m_ccq = 1; m_req = 0; m_data = '0;
    end else begin
      m_vs  = m_ccq && !cc;
      m_ent = !m_ccq && cc;
      m_ov  = 0;
      m_req = 0;
      if (!cc) begin
        if (m_vs) begin m_win = 0; m_err = 0; end
        if (err) begin
          m_err = m_err + 1;
          if (m_err == LIM + 1) m_ov = 1;
        end
        m_win = m_win + 1;
        if (m_win == WIN) begin m_win = 0; m_err = 0; end
        m_data = din;
      end
      if (m_vs) begin
        m_req  = !m_bad;
        m_pend = !m_bad;
        m_bad  = 0;
      end else if (m_ent) begin
        if (m_pend) begin m_pend = 0; m_lock = 0; end
      end else if (m_pend) begin
        if (fl)      begin m_pend = 0; m_lock = 0; end
        else if (ok) begin m_pend = 0; m_lock = 1; end
      end
      if (m_ov) begin m_lock = 0; m_bad = 1; m_pend = 0; end
      m_ccq = cc;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 R2 R4 R5 R6 lock_o", 32'(lock_o), 32'(m_lock));
    chk("R3 frame_req_o", 32'(frame_req_o), 32'(m_req));
    chk("R8 cc_active_o", 32'(cc_active_o), 32'(m_ccq));
    chk("R7 vid_data_o", 32'(vid_data_o), 32'(m_data));
  endtask

  task automatic step(bit c, bit e, bit o, bit f);
    @(negedge clk);
    compare_all();
    cc = c; err = e; ok = o; fl = f; din = DW'($urandom);
  endtask

  task automatic ccp(int n, bit noisy);
    for (int i = 0; i < n; i++) step(1'b1, noisy, noisy, 1'b0);
  endtask

  task automatic vid(int n, int every);
    for (int i = 0; i < n; i++)
      step(1'b0, (every > 0) && (i % every == every - 1), 1'b0, 1'b0);
  endtask

  task automatic hs(bit o, bit f);
    step(1'b0, 1'b0, o, f);
    step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 lock_o", 32'(lock_o), 0);
    chk("R9 frame_req_o", 32'(frame_req_o), 0);
    chk("R9 cc_active_o", 32'(cc_active_o), 1);
    chk("R9 vid_data_o", 32'(vid_data_o), 0);
    rst = 1'b0;

    ccp(4, 1'b0);
    vid(2, 0);
    chk("R3 request after clean start", 32'(frame_req_o), 1);
    hs(1'b1, 1'b0);
    chk("R4 lock after ok", 32'(lock_o), 1);

    vid(48, 6);                       // at most LIM errors per window
    chk("R1 at-limit errors keep lock", 32'(lock_o), 1);

    ccp(6, 1'b1);                     // errors and ok during control ignored
    chk("R6 lock held in control", 32'(lock_o), 1);
    vid(2, 0);
    chk("R1 R3 request after noisy control", 32'(frame_req_o), 1);
    hs(1'b1, 1'b0);

    vid(4, 0);
    vid(8, 1);                        // burst crosses limit in some window
    chk("R2 lock lost on burst", 32'(lock_o), 0);
    vid(20, 0);
    ccp(3, 1'b0);
    vid(2, 0);
    chk("R2 no request after bad phase", 32'(frame_req_o), 0);
    hs(1'b1, 1'b0);
    chk("R5 ok ignored without pending", 32'(lock_o), 0);

    ccp(3, 1'b0); vid(2, 0);
    hs(1'b0, 1'b1);
    chk("R4 fail keeps lock low", 32'(lock_o), 0);
    ccp(3, 1'b0); vid(2, 0);
    hs(1'b1, 1'b1);
    chk("R4 fail wins over ok", 32'(lock_o), 0);
    ccp(3, 1'b0); vid(2, 0);
    hs(1'b1, 1'b0);
    chk("R4 lock regained", 32'(lock_o), 1);

    ccp(3, 1'b0); vid(2, 0);
    ccp(2, 1'b0);
    chk("R6 control entry while pending drops lock", 32'(lock_o), 0);

    // Mixed random traffic, compared every cycle
    for (int r = 0; r < 300; r++) begin
      int nv = 2 + int'($urandom % 40);
      int nc = 1 + int'($urandom % 6);
      for (int i = 0; i < nv; i++)
        step(1'b0, ($urandom % 9) == 0, ($urandom % 5) == 0, ($urandom % 23) == 0);
      for (int i = 0; i < nc; i++)
        step(1'b1, ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 7) == 0);
    end
    step(1'b1, 1'b0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule